// File: doc/BRIEF.md
# Cacheless Instruction Fetch with Reorder Buffer

This block connects a fetch pipeline straight to an instruction memory bus, with no cache in between. A program counter enters through a valid/ready handshake. An optional register stage holds it, and from there the block issues one read of a full fetch word. The read address is the PC with its byte-offset bits cleared, and each read carries a transaction tag.

Each outstanding read owns one slot of a small buffer, and the slot number is the tag. Memory may answer in any order. Each answer is written into its slot, and a head pointer hands the words to the consuming stage strictly in issue order. An optional output register can sit in that path. A bus error bit travels with every word, so that a later stage can raise an access fault.

A flush drops whatever is in the stage registers. Reads that are still in flight are marked to be discarded. Their answers are still taken and their slots are freed, but the words are never passed on.

Top module: `fetch_nocache`

## Requirements
- R1: After reset, `outValid` and `reqValid` are 0 and `pcReady` is 1.
- R2: `reqAddr` equals the accepted PC with its low log2(WORD_W/8) bits forced to 0 (bits [1:0] for a 32-bit word). The upper bits are unchanged.
- R3: `reqId` is the slot number. The n-th request issued since reset (counting from 0) carries tag n mod SLOTS.
- R4: At most SLOTS reads are outstanding. While every slot is held, `reqValid` stays 0 even when a PC is waiting.
- R5: Words leave on `outWord` in the order their requests were issued, whatever order the responses arrive in.
- R6: No word is presented until the response for the oldest outstanding request has arrived, even if younger ones have arrived.
- R7: `outErr` equals the `rspErr` bit that arrived with that word.
- R8: After `flush`, no response to a request issued before the flush is ever forwarded. A slot whose response arrives after the flush is freed for reuse, and so is a slot whose response had already arrived but had not been delivered. `outValid` is 0 in the cycle after a flush.
- R9: A response that arrives in the same cycle as `flush` is discarded and its slot is freed.
- R10: While `outValid` is 1 and `outReady` is 0 (no flush), `outValid` and `outWord` hold. While `reqValid` is 1 and `reqReady` is 0 (no flush), `reqValid` and `reqAddr` hold.
- R11: With default parameters, a request appears in the cycle after its PC is accepted. With the output free, the word for the head slot appears two cycles after its response is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Cancel all older fetches |
| pcValid | input | 1 | A PC is offered |
| pcAddr | input | PC_W | Fetch PC, any byte alignment |
| pcReady | output | 1 | The PC is taken this cycle |
| reqValid | output | 1 | Memory read request valid |
| reqReady | input | 1 | Memory accepts the request |
| reqAddr | output | PC_W | Word-aligned read address |
| reqId | output | IDW | Transaction tag (slot number) |
| rspValid | input | 1 | Memory response valid |
| rspId | input | IDW | Tag of the response |
| rspData | input | WORD_W | Fetched word |
| rspErr | input | 1 | Bus error for this word |
| outValid | output | 1 | Word presented to the join stage |
| outReady | input | 1 | Join stage takes the word |
| outWord | output | WORD_W | Fetched word in program order |
| outErr | output | 1 | Bus error that came with the word |

## Verification
Two events can fall in the same cycle: a memory response arriving and a flush. The bench drives `flush` together with the response for the youngest outstanding tag. Two older responses are already stored behind a missing head, and the head response arrives after the flush. The result is judged at the ports. No word may appear after the flush, and a fresh batch of SLOTS requests must then issue in full, which shows that every slot was freed. Around this case, all 24 response orders of a four-deep batch are swept, with and without output backpressure.

// File: rtl/fetch_nocache_pkg.sv
package fetch_nocache_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic forkLoad;   // capture PC into fork register
    logic rspWrite;   // store response word into its slot
    logic joinLoad;   // move head word into join register
  } fetchStrobes_t;

endpackage

// File: rtl/fetch_nocache_ctrl.sv
module fetch_nocache_ctrl
  import fetch_nocache_pkg::*;
#(
  parameter int SLOTS    = 4,
  parameter bit FORK_REG = 1'b1,
  parameter bit JOIN_REG = 1'b1,
  localparam int IDW     = $clog2(SLOTS)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           flush,
  input  logic           pcValid,
  output logic           pcReady,
  output logic           reqValid,
  input  logic           reqReady,
  output logic [IDW-1:0] reqId,
  input  logic           rspValid,
  input  logic [IDW-1:0] rspId,
  output logic           outValid,
  input  logic           outReady,
  output logic [IDW-1:0] headId,
  output fetchStrobes_t  strobes
);

  logic [SLOTS-1:0] busy, done, disc;
  logic [IDW-1:0]   allocPtr, headPtr;
  logic             forkValid, issueFire, headReady, pop;

  function automatic logic [IDW-1:0] bumpPtr(input logic [IDW-1:0] p);
    return (p == IDW'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign reqValid  = forkValid && !busy[allocPtr] && !flush;
  assign issueFire = reqValid && reqReady;
  assign reqId     = allocPtr;
  assign headId    = headPtr;
  assign headReady = busy[headPtr] && done[headPtr] && !disc[headPtr];

  generate
    if (FORK_REG) begin : g_forkReg
      logic forkValidR;
      assign forkValid = forkValidR;
      assign pcReady   = (!forkValidR || issueFire) && !flush;
      always_ff @(posedge clk) begin
        if (!rstN || flush)           forkValidR <= 1'b0;
        else if (pcValid && pcReady)  forkValidR <= 1'b1;
        else if (issueFire)           forkValidR <= 1'b0;
      end
    end else begin : g_forkWire
      assign forkValid = pcValid;
      assign pcReady   = issueFire;
    end

    if (JOIN_REG) begin : g_joinReg
      logic outValidR;
      assign outValid = outValidR;
      assign pop      = headReady && (!outValidR || outReady) && !flush;
      always_ff @(posedge clk) begin
        if (!rstN || flush) outValidR <= 1'b0;
        else if (pop)       outValidR <= 1'b1;
        else if (outReady)  outValidR <= 1'b0;
      end
    end else begin : g_joinWire
      assign outValid = headReady && !flush;
      assign pop      = outValid && outReady;
    end
  endgenerate

  assign strobes.forkLoad = pcValid && pcReady;
  assign strobes.rspWrite = rspValid;
  assign strobes.joinLoad = pop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      allocPtr <= '0;
      headPtr  <= '0;
    end else begin
      if (issueFire) allocPtr <= bumpPtr(allocPtr);
      if (flush)     headPtr  <= issueFire ? bumpPtr(allocPtr) : allocPtr;
      else if (pop)  headPtr  <= bumpPtr(headPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= '0;
      done <= '0;
      disc <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (issueFire && allocPtr == IDW'(i)) begin
          busy[i] <= 1'b1;
          done[i] <= 1'b0;
          disc[i] <= 1'b0;
        end else if (rspValid && rspId == IDW'(i) && busy[i]) begin
          if (disc[i] || flush) begin
            busy[i] <= 1'b0;
            done[i] <= 1'b0;
            disc[i] <= 1'b0;
          end else begin
            done[i] <= 1'b1;
          end
        end else if (flush && busy[i]) begin
          if (done[i]) begin
            busy[i] <= 1'b0;
            done[i] <= 1'b0;
          end else begin
            disc[i] <= 1'b1;
          end
        end else if (pop && headPtr == IDW'(i)) begin
          busy[i] <= 1'b0;
          done[i] <= 1'b0;
        end
      end
    end
  end

  // R4
  rsp_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (busy[rspId] && !done[rspId]));

  // R8
  disc_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && disc[rspId]) |=> !busy[$past(rspId)]);

  // R9
  flush_rsp_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && flush) |=> !busy[$past(rspId)]);

  // R8
  flush_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !outValid);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady && !flush) |=> (reqValid || flush));

endmodule

// File: rtl/fetch_nocache_dp.sv
module fetch_nocache_dp
  import fetch_nocache_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int WORD_W   = 32,
  parameter int SLOTS    = 4,
  parameter bit FORK_REG = 1'b1,
  parameter bit JOIN_REG = 1'b1,
  localparam int IDW     = $clog2(SLOTS),
  localparam int OFF     = $clog2(WORD_W / 8)
) (
  input  logic              clk,
  input  fetchStrobes_t     strobes,
  input  logic [PC_W-1:0]   pcAddr,
  input  logic [IDW-1:0]    rspId,
  input  logic [WORD_W-1:0] rspData,
  input  logic              rspErr,
  input  logic [IDW-1:0]    headId,
  output logic [PC_W-1:0]   reqAddr,
  output logic [WORD_W-1:0] outWord,
  output logic              outErr
);

  logic [WORD_W-1:0] slotWord [SLOTS];
  logic              slotErr  [SLOTS];
  logic [PC_W-1:0]   forkPc;

  generate
    if (FORK_REG) begin : g_forkPc
      logic [PC_W-1:0] forkPcR;
      always_ff @(posedge clk) begin
        if (strobes.forkLoad) forkPcR <= pcAddr;
      end
      assign forkPc = forkPcR;
    end else begin : g_forkPcWire
      assign forkPc = pcAddr;
    end
  endgenerate

  assign reqAddr = {forkPc[PC_W-1:OFF], {OFF{1'b0}}};

  always_ff @(posedge clk) begin
    if (strobes.rspWrite) begin
      slotWord[rspId] <= rspData;
      slotErr[rspId]  <= rspErr;
    end
  end

  generate
    if (JOIN_REG) begin : g_joinData
      logic [WORD_W-1:0] joinWord;
      logic              joinErr;
      always_ff @(posedge clk) begin
        if (strobes.joinLoad) begin
          joinWord <= slotWord[headId];
          joinErr  <= slotErr[headId];
        end
      end
      assign outWord = joinWord;
      assign outErr  = joinErr;
    end else begin : g_joinDataWire
      assign outWord = slotWord[headId];
      assign outErr  = slotErr[headId];
    end
  endgenerate

endmodule

// File: rtl/fetch_nocache.sv
module fetch_nocache
  import fetch_nocache_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int WORD_W   = 32,
  parameter int SLOTS    = 4,
  parameter bit FORK_REG = 1'b1,
  parameter bit JOIN_REG = 1'b1,
  localparam int IDW     = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              pcValid,
  input  logic [PC_W-1:0]   pcAddr,
  output logic              pcReady,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [PC_W-1:0]   reqAddr,
  output logic [IDW-1:0]    reqId,
  input  logic              rspValid,
  input  logic [IDW-1:0]    rspId,
  input  logic [WORD_W-1:0] rspData,
  input  logic              rspErr,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outWord,
  output logic              outErr
);

  fetchStrobes_t  strobes;
  logic [IDW-1:0] headId;

  fetch_nocache_ctrl #(
    .SLOTS(SLOTS), .FORK_REG(FORK_REG), .JOIN_REG(JOIN_REG)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush),
    .pcValid(pcValid), .pcReady(pcReady),
    .reqValid(reqValid), .reqReady(reqReady), .reqId(reqId),
    .rspValid(rspValid), .rspId(rspId),
    .outValid(outValid), .outReady(outReady),
    .headId(headId), .strobes(strobes)
  );

  fetch_nocache_dp #(
    .PC_W(PC_W), .WORD_W(WORD_W), .SLOTS(SLOTS),
    .FORK_REG(FORK_REG), .JOIN_REG(JOIN_REG)
  ) u_dp (
    .clk(clk), .strobes(strobes), .pcAddr(pcAddr),
    .rspId(rspId), .rspData(rspData), .rspErr(rspErr),
    .headId(headId), .reqAddr(reqAddr),
    .outWord(outWord), .outErr(outErr)
  );

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !flush) |=> ((outValid && $stable(outWord)) || flush));

  // R10
  req_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady && !flush) |=> ($stable(reqAddr) || flush));

endmodule

// File: tb/fetch_nocache_bench.sv
`timescale 1ns/1ps
module fetch_nocache_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        pcValid = 1'b0;
  logic [31:0] pcAddr = '0;
  logic        pcReady;
  logic        reqValid;
  logic        reqReady = 1'b1;
  logic [31:0] reqAddr;
  logic [1:0]  reqId;
  logic        rspValid = 1'b0;
  logic [1:0]  rspId = '0;
  logic [31:0] rspData = '0;
  logic        rspErr = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outWord;
  logic        outErr;

  always #5 clk = ~clk;

  fetch_nocache u_fetch_nocache (
    .clk(clk), .rstN(rstN), .flush(flush),
    .pcValid(pcValid), .pcAddr(pcAddr), .pcReady(pcReady),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqId(reqId),
    .rspValid(rspValid), .rspId(rspId), .rspData(rspData), .rspErr(rspErr),
    .outValid(outValid), .outReady(outReady), .outWord(outWord), .outErr(outErr)
  );

  int checks = 0;
  int fails = 0;
  int issueCnt = 0;
  int pushCnt = 0;
  int outFires = 0;
  int cyc = 0;
  bit stallMode = 1'b0;
  logic [31:0] slotAddr [4];
  logic [31:0] expQ [$];
  logic [31:0] pcQ [$];
  bit          stallPrev = 1'b0;
  logic [31:0] stallWord = '0;

  function automatic logic [31:0] dataOf(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0]};
  endfunction

  function automatic logic errOf(input logic [31:0] a);
    return a[4] ^ a[7];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    outReady <= stallMode ? (cyc % 3 != 0) : 1'b1;
  end

  // monitor on the active edge: inputs only change at negedges
  always @(posedge clk) begin
    if (rstN) begin
      if (stallPrev) chk(outValid && outWord == stallWord, "R10 output hold", outWord, stallWord);
      stallPrev = outValid && !outReady && !flush;
      stallWord = outWord;
      if (flush) begin
        expQ.delete();
        pcQ.delete();
      end else begin
        if (pcValid && pcReady) pcQ.push_back(pcAddr);
        if (outValid && outReady) begin
          outFires++;
          if (expQ.size() == 0) chk(1'b0, "R8 unexpected word", outWord, 32'h0);
          else begin
            logic [31:0] a;
            a = expQ.pop_front();
            chk(outWord == dataOf(a), "R5 order", outWord, dataOf(a));
            chk(outErr == errOf(a), "R7 error flag", {31'b0, outErr}, {31'b0, errOf(a)});
          end
        end
        if (reqValid && reqReady) begin
          logic [31:0] p;
          p = (pcQ.size() > 0) ? pcQ.pop_front() : 32'hDEAD_BEEF;
          chk(reqAddr == {p[31:2], 2'b00}, "R2 aligned address", reqAddr, {p[31:2], 2'b00});
          chk(reqId == 2'(issueCnt % 4), "R3 tag", {30'b0, reqId}, issueCnt % 4);
          slotAddr[reqId] = reqAddr;
          expQ.push_back(reqAddr);
          issueCnt++;
        end
      end
    end
  end

  task automatic pushPc();
    pcValid = 1'b1;
    pcAddr  = 32'h0000_1000 + pushCnt * 4 + (pushCnt % 4);
    pushCnt++;
    #1;
    while (!pcReady) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    pcValid = 1'b0;
  endtask

  task automatic sendRsp(input int id);
    rspValid = 1'b1;
    rspId    = 2'(id);
    rspData  = dataOf(slotAddr[id]);
    rspErr   = errOf(slotAddr[id]);
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  task automatic waitIssued(input int n, input string tag);
    int t = 0;
    while (issueCnt < n && t < 300) begin
      @(negedge clk);
      t++;
    end
    chk(issueCnt >= n, tag, issueCnt, n);
  endtask

  task automatic waitDrain(input string tag);
    int t = 0;
    while (expQ.size() != 0 && t < 300) begin
      @(negedge clk);
      t++;
    end
    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, tag, expQ.size(), 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int b;
    int fo;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(outValid == 1'b0, "R1 outValid", {31'b0, outValid}, 0);
    chk(reqValid == 1'b0, "R1 reqValid", {31'b0, reqValid}, 0);
    chk(pcReady == 1'b1, "R1 pcReady", {31'b0, pcReady}, 1);
    @(negedge clk);

    // R11 latency through fork and join registers
    pcValid = 1'b1;
    pcAddr  = 32'h0000_0A57;
    pushCnt++;
    @(negedge clk);
    pcValid = 1'b0;
    chk(reqValid == 1'b1, "R11 request one cycle after accept", {31'b0, reqValid}, 1);
    chk(reqAddr == 32'h0000_0A54, "R2 aligned address", reqAddr, 32'h0000_0A54);
    @(negedge clk);
    sendRsp(0);
    chk(outValid == 1'b0, "R11 word not yet out", {31'b0, outValid}, 0);
    @(negedge clk);
    chk(outValid == 1'b1 && outWord == dataOf(32'h0000_0A54), "R11 word two cycles after response",
        outWord, dataOf(32'h0000_0A54));
    waitDrain("R5 drain after latency test");

    // R10 request hold under bus backpressure
    reqReady = 1'b0;
    pushPc();
    begin
      logic [31:0] held;
      held = reqAddr;
      repeat (3) begin
        @(negedge clk);
        chk(reqValid == 1'b1 && reqAddr == held, "R10 request hold", reqAddr, held);
      end
    end
    reqReady = 1'b1;
    waitIssued(issueCnt + 1, "R10 request issued after release");
    sendRsp((issueCnt - 1) % 4);
    waitDrain("R10 drain");

    // R5 R6 R7: sweep of all 24 response orders, second half with output stalls
    for (int p = 0; p < 24; p++) begin
      int pool[4];
      int perm[4];
      int d;
      int left;
      stallMode = (p >= 12);
      for (int k = 0; k < 4; k++) pool[k] = k;
      d = p;
      left = 4;
      for (int k = 0; k < 4; k++) begin
        int ix;
        ix = d % left;
        d = d / left;
        perm[k] = pool[ix];
        for (int m = ix; m < 3; m++) pool[m] = pool[m + 1];
        left--;
      end
      b = issueCnt;
      for (int k = 0; k < 4; k++) pushPc();
      waitIssued(b + 4, "R4 batch of four issued");
      fo = outFires;
      for (int k = 0; k < 4; k++) begin
        sendRsp((b + perm[k]) % 4);
        if (k == 2 && perm[3] == 0) begin
          repeat (2) @(negedge clk);
          chk(outValid == 1'b0 && outFires == fo, "R6 wait for head", {31'b0, outValid}, 0);
        end
      end
      waitDrain("R5 batch drained");
    end
    stallMode = 1'b0;
    repeat (2) @(negedge clk);

    // R4 all slots held: a waiting PC is not issued
    b = issueCnt;
    for (int k = 0; k < 5; k++) pushPc();
    repeat (4) @(negedge clk);
    chk(reqValid == 1'b0, "R4 no request while full", {31'b0, reqValid}, 0);
    chk(issueCnt == b + 4, "R4 outstanding limit", issueCnt, b + 4);
    sendRsp((b + 2) % 4);
    sendRsp(b % 4);
    sendRsp((b + 3) % 4);
    sendRsp((b + 1) % 4);
    waitIssued(b + 5, "R4 fifth issued after a slot frees");
    sendRsp((b + 4) % 4);
    waitDrain("R4 drain");

    // R8 R9 flush with a response arriving in the same cycle
    b = issueCnt;
    for (int k = 0; k < 4; k++) pushPc();
    waitIssued(b + 4, "R8 pre-flush batch issued");
    sendRsp((b + 1) % 4);
    sendRsp((b + 2) % 4);
    repeat (2) @(negedge clk);
    chk(outValid == 1'b0, "R6 head missing", {31'b0, outValid}, 0);
    fo = outFires;
    flush = 1'b1;
    sendRsp((b + 3) % 4);
    flush = 1'b0;
    #1;
    chk(outValid == 1'b0, "R8 outValid after flush", {31'b0, outValid}, 0);
    @(negedge clk);
    sendRsp(b % 4);
    repeat (5) @(negedge clk);
    chk(outFires == fo, "R8 R9 nothing forwarded after flush", outFires, fo);
    b = issueCnt;
    for (int k = 0; k < 4; k++) pushPc();
    waitIssued(b + 4, "R9 all slots freed after flush");
    sendRsp((b + 3) % 4);
    sendRsp((b + 1) % 4);
    sendRsp(b % 4);
    sendRsp((b + 2) % 4);
    waitDrain("R8 post-flush batch delivered");
    chk(outFires == fo + 4, "R8 post-flush word count", outFires, fo + 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule